// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM that keeps its data bus busy on every cycle, whatever the mix of reads and writes. A read returns its word one cycle after the command edge. A write takes its data two enabled edges after the command. Because the two latencies line up on the data bus, a controller can issue any pattern of reads and writes back to back with no idle cycle between them. The array depth is a parameter. Each word is made of byte lanes that are nine bits wide, and a write mask selects which lanes a write updates.

Commands are sampled on the rising clock edge. A command either loads an external address, continues a four-beat burst from an internal 2-bit counter, or deselects the part. A clock-enable stall freezes every register. An asynchronous sleep input parks the block after a short delay. The data bus is split into an input and an output. A drive flag takes the place of a tristate and falls at once when output enable is high.

Top module: `nt_sram`

## Requirements
- R1: While reset is low and after it is released, no operation is pending and `dout_vld` is 0. Reset does not clear the array.
- R2: On an edge where `cke_n` is 1, all inputs are ignored and every internal register holds its value, including the pipeline stages, the burst counter and the output word.
- R3: An enabled edge with `adv_ld_n`=0 loads `addr` when all three selects are active (`cs_a_n`=0, `cs_b`=1, `cs_c_n`=0). `we_n`=1 starts a read and `we_n`=0 starts a write. If any select is inactive, the part is deselected, and later edges with `adv_ld_n`=1 keep it deselected.
- R4: A read commanded at enabled edge k puts its word on `dout` with `dout_vld`=1 after enabled edge k+1, provided `oe_n` is 0.
- R5: A write commanded at enabled edge k samples `din` at enabled edge k+2. Lane i is bits [9i+8:9i] and is written only if `bw_n[i]` was 0 at the command edge.
- R6: A write command with every `bw_n` bit at 1 changes no array contents.
- R7: `adv_ld_n`=1 on an active burst issues the same operation type at the next burst address. The upper address bits stay fixed. With `burst_ilv`=0, the low two bits are (start + n) mod 4. With `burst_ilv`=1, they are start XOR n. After four beats the sequence wraps to the start.
- R8: Reads and writes may follow each other on consecutive edges in any order with no idle cycle, and every read returns the correct data.
- R9: A read of an address whose earlier write has not yet reached the array returns the merged bytes of that write.
- R10: `oe_n`=1 forces `dout_vld` to 0 without a clock. The read pipeline keeps running, so data reappears when `oe_n` returns to 0.
- R11: When `sleep` is sampled high at edge t, edges from t+2 onward are ignored and `dout_vld` is 0 after edge t+1. When `sleep` falls, normal sampling resumes two edges later. The array contents are preserved throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | 0 selects write, 1 selects read, on a load |
| bw_n | input | LANES | Active-low lane write strobes |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Asynchronous active-high sleep request |
| din | input | LANES*LANE_W | Write data, sampled two edges after the command |
| dout | output | LANES*LANE_W | Read data |
| dout_vld | output | 1 | High when `dout` is driven |

## Verification
The bench targets the cases below.
- A read on the edge right after a write to the same address. A design without forwarding would return the stale word, and one with a wrong lane mask would merge the wrong bytes.
- Bursts that start at every low-address offset in both orders. These catch a counter that carries into the upper bits, or that uses addition where XOR is needed.
- Stalls placed between a write command and its data edge. A design that counts raw clocks instead of enabled edges would capture the wrong `din`.
- A continue after a deselect, and sleep entered and left with commands on the bus. These expose a part that wakes on a stray advance or acts on ignored edges.

// File: rtl/nt_sram.sv
`timescale 1ns/1ps
module nt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_n,
  input  logic                      cs_a_n,
  input  logic                      cs_b,
  input  logic                      cs_c_n,
  input  logic                      adv_ld_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      oe_n,
  input  logic                      burst_ilv,
  input  logic                      sleep,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_vld
);
  localparam int DW    = LANES*LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic s1, s2;
  logic en, sel;
  logic b_act, b_wr;
  logic [ADDR_W-1:0] b_base;
  logic [1:0] b_cnt, cnt_nx, lo_nx;
  logic iss_v, iss_wr;
  logic [ADDR_W-1:0] iss_a;
  logic p1_v, p1_wr, p2_v, p2_wr;
  logic [ADDR_W-1:0] p1_a, p2_a;
  logic [LANES-1:0] p1_m, p2_m;
  logic rd_vld;
  logic [DW-1:0] rd_dat, fwd;

  assign en     = !cke_n && !s2;
  assign sel    = !cs_a_n && cs_b && !cs_c_n;
  assign cnt_nx = b_cnt + 2'd1;
  assign lo_nx  = burst_ilv ? (b_base[1:0] ^ cnt_nx) : (b_base[1:0] + cnt_nx);
  assign iss_v  = adv_ld_n ? b_act : sel;
  assign iss_wr = adv_ld_n ? b_wr : !we_n;
  assign iss_a  = adv_ld_n ? {b_base[ADDR_W-1:2], lo_nx} : addr;

  always_comb begin
    fwd = mem[p1_a];
    for (int l = 0; l < LANES; l++)
      if (p2_v && p2_wr && (p2_a == p1_a) && p2_m[l])
        fwd[l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;  s2 <= 1'b0;
      b_act <= 1'b0;  b_wr <= 1'b0;  b_base <= '0;  b_cnt <= '0;
      p1_v <= 1'b0;  p1_wr <= 1'b0;  p1_a <= '0;  p1_m <= '0;
      p2_v <= 1'b0;  p2_wr <= 1'b0;  p2_a <= '0;  p2_m <= '0;
      rd_vld <= 1'b0;  rd_dat <= '0;
    end else begin
      s1 <= sleep;
      s2 <= s1;
      if (en) begin
        if (!adv_ld_n) begin
          b_act  <= sel;
          b_wr   <= !we_n;
          b_base <= addr;
          b_cnt  <= '0;
        end else if (b_act) begin
          b_cnt  <= cnt_nx;
        end
        p1_v  <= iss_v;
        p1_wr <= iss_wr;
        p1_a  <= iss_a;
        p1_m  <= ~bw_n;
        p2_v  <= p1_v;
        p2_wr <= p1_wr;
        p2_a  <= p1_a;
        p2_m  <= p1_m;
        rd_vld <= p1_v && !p1_wr;
        if (p1_v && !p1_wr) rd_dat <= fwd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && p2_v && p2_wr)
      for (int l = 0; l < LANES; l++)
        if (p2_m[l]) mem[p2_a][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
  end

  assign dout     = rd_dat;
  assign dout_vld = rd_vld && !oe_n && !s2;

  a_r2_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rd_vld) && $stable(rd_dat) && $stable(p1_v) && $stable(p2_v) && $stable(b_cnt)));

  a_r3_deselect_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld_n && !sel) |=> !p1_v);

  a_r4_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (en && p1_v && !p1_wr) |=> rd_vld);

  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld_n && b_act) |=> (b_cnt == $past(b_cnt) + 2'd1));

  a_r11_sleep_float: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep, 2) && $past(rst_n, 2)) |-> !dout_vld);
endmodule

// File: tb/nt_sram_bench.sv
`timescale 1ns/1ps
module nt_sram_bench;
  localparam int AW = 8;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN*LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b0, cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic adv_ld_n = 1'b0, we_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic oe_n = 1'b0, burst_ilv = 1'b0, sleep = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_vld;

  always #2 clk = ~clk;

  nt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_nt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n),
    .addr(addr), .oe_n(oe_n), .burst_ilv(burst_ilv), .sleep(sleep),
    .din(din), .dout(dout), .dout_vld(dout_vld));

  int n_run = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  logic [DW-1:0] rmem [DEPTH];
  int wq_a[$], wq_m[$], wq_age[$];
  bit rd_pend, exp_vld, sl1, sl2, b_on, b_w;
  int rd_a, b_start, b_n;
  logic [DW-1:0] exp_dat;

  task automatic issue(int a, bit w);
    if (w) begin wq_a.push_back(a); wq_m.push_back(int'(~bw_n)); wq_age.push_back(0); end
    else begin rd_pend = 1; rd_a = a; end
  endtask

  task automatic model_edge();
    bit ign;
    int lo;
    if (!rst_n) begin
      wq_a.delete(); wq_m.delete(); wq_age.delete();
      rd_pend = 0; exp_vld = 0; sl1 = 0; sl2 = 0; b_on = 0;
      return;
    end
    ign = sl2; sl2 = sl1; sl1 = sleep;
    if (cke_n || ign) return;
    while (wq_a.size() > 0 && wq_age[0] == 1) begin
      for (int l = 0; l < LN; l++)
        if (wq_m[0][l]) rmem[wq_a[0]][l*LW +: LW] = din[l*LW +: LW];
      void'(wq_a.pop_front()); void'(wq_m.pop_front()); void'(wq_age.pop_front());
    end
    exp_vld = rd_pend;
    if (rd_pend) exp_dat = rmem[rd_a];
    rd_pend = 0;
    foreach (wq_age[i]) wq_age[i]++;
    if (!adv_ld_n) begin
      if (!cs_a_n && cs_b && !cs_c_n) begin
        b_on = 1; b_w = !we_n; b_start = int'(addr); b_n = 0;
        issue(b_start, b_w);
      end else b_on = 0;
    end else if (b_on) begin
      b_n = (b_n + 1) % 4;
      lo = burst_ilv ? ((b_start ^ b_n) & 3) : ((b_start + b_n) & 3);
      issue((b_start & ~3) | lo, b_w);
    end
  endtask

  always @(posedge clk) model_edge();

  always @(negedge clk) begin
    bit drv;
    if (rst_n) begin
      drv = exp_vld && !oe_n && !sl2;
      n_run++;
      if (dout_vld !== drv) begin
        n_fail++;
        $display("FAIL %s: dout_vld=%0b expected %0b at cycle %0d", cur_req, dout_vld, drv, cyc);
      end else if (drv) begin
        n_run++;
        if (dout !== exp_dat) begin
          n_fail++;
          $display("FAIL %s: dout=%h expected %h at cycle %0d", cur_req, dout, exp_dat, cyc);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic put(bit ck, int off, bit adv, bit we, logic [LN-1:0] bw, int a);
    cke_n = ck; cs_a_n = (off == 1); cs_b = (off != 2); cs_c_n = (off == 3);
    adv_ld_n = adv; we_n = we; bw_n = bw; addr = a[AW-1:0];
    din = DW'($urandom);
    @(posedge clk); #1;
  endtask

  task automatic rd(int a);           put(0, 0, 0, 1, '1, a); endtask
  task automatic wr(int a, int bw);   put(0, 0, 0, 0, bw[LN-1:0], a); endtask
  task automatic dsel();              put(0, 1, 0, 1, '1, 0); endtask
  task automatic cont(int bw);        put(0, 0, 1, 1, bw[LN-1:0], 0); endtask

  task automatic rnd_put(int stall_pct, int amask);
    put(($urandom % 100) < stall_pct, ($urandom % 8 == 0) ? 1 + $urandom % 3 : 0,
        $urandom % 3 == 0, $urandom % 2, LN'($urandom), int'($urandom) & amask);
  endtask

  initial begin
    #1;
    cur_req = "R1";
    repeat (3) dsel();
    rst_n = 1'b1;
    repeat (3) dsel();

    cur_req = "R5";
    for (int a = 0; a < DEPTH; a++) wr(a, 0);
    repeat (3) dsel();

    cur_req = "R4";
    for (int i = 0; i < 24; i++) rd($urandom % DEPTH);
    repeat (2) dsel();

    cur_req = "R6";
    for (int i = 0; i < 8; i++) begin
      int a = $urandom % DEPTH;
      wr(a, 3); dsel(); dsel(); rd(a); dsel();
    end

    cur_req = "R5";
    for (int i = 0; i < 16; i++) begin
      int a = $urandom % DEPTH;
      wr(a, i % 4); dsel(); dsel(); dsel(); rd(a); dsel();
    end

    cur_req = "R7";
    for (int ilv = 0; ilv < 2; ilv++) begin
      burst_ilv = ilv[0];
      for (int s = 0; s < 4; s++) begin
        wr(64 + 4*s + s, 0);
        for (int k = 0; k < 5; k++) cont($urandom % 4);
        dsel(); dsel();
        rd(64 + 4*s + s);
        for (int k = 0; k < 6; k++) cont(3);
        dsel(); dsel();
      end
    end
    burst_ilv = 1'b0;

    cur_req = "R3";
    for (int off = 1; off < 4; off++) begin
      rd(5); cont(3); put(0, off, 0, 1, '1, 9); cont(3); cont(3); rd(9); put(0, off, 0, 0, '0, 9);
      cont(0); dsel(); rd(9); dsel(); dsel();
    end

    cur_req = "R9";
    for (int i = 0; i < 12; i++) begin
      int a = $urandom % 8;
      wr(a, $urandom % 4); rd(a); rd(a); wr(a, $urandom % 4); dsel(); rd(a);
    end
    wr(40, 0); cont(1); cont(2); cont(0); rd(40); cont(3); cont(3); cont(3); dsel(); dsel();

    cur_req = "R8";
    for (int i = 0; i < 300; i++) put(0, 0, 0, $urandom % 2, LN'($urandom), $urandom % 8);
    repeat (3) dsel();

    cur_req = "R2";
    for (int i = 0; i < 400; i++) rnd_put(35, 15);
    repeat (3) dsel();

    cur_req = "R10";
    for (int i = 0; i < 300; i++) begin
      oe_n = ($urandom % 3 == 0);
      rnd_put(10, 15);
    end
    oe_n = 1'b0;
    repeat (3) dsel();

    cur_req = "R11";
    for (int r = 0; r < 4; r++) begin
      rd(3); rd(4);
      sleep = 1'b1;
      for (int i = 0; i < 10; i++) rnd_put(20, 15);
      sleep = 1'b0;
      repeat (3) dsel();
      for (int i = 0; i < 8; i++) rd(i);
      dsel();
    end

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      oe_n = ($urandom % 10 == 0);
      burst_ilv = (i / 500) % 2 == 1;
      rnd_put(15, 31);
    end
    oe_n = 1'b0;
    repeat (4) dsel();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule